// File: doc/BRIEF.md
# TDM Eight-Slot Receiver with Auxiliary Stereo Forwarding

This block takes in a time-division multiplexed serial stream made of eight 32-bit slots per frame and turns each frame into eight parallel channel words. It runs on a fast system clock and oversamples the incoming bit clock, frame clock and data lines. A programmable edge of the bit clock picks when data is taken. An active edge of the frame clock marks the start of slot 1.

When auxiliary forwarding is on, the block does not deliver the last four slots of each frame on its parallel outputs. It sends them instead as two I2S stereo streams that share one auxiliary bit clock and one word clock. External stereo converters can read these streams, which lets a system carry more channels than the host device has. The auxiliary streams run one frame behind the input. Their bit clock runs at one quarter of the input bit rate.

Top module: `tdm_slot_splitter`

## Requirements
- R1: A frame is 8 slots of 32 bit clocks. The first bit after the frame clock goes active (inactive on the previous sampled bit) is bit 0 of slot 0. Slot s is delivered on `ch_words[s*24 +: 24]`, and slots alternate left/right channels, so slot 0 is left 1, slot 1 is right 1, and so on.
- R2: A slot carries its sample MSB first from the slot boundary. The word is left-aligned into 24 bits. `cfg_wlen` selects the width: 00 = 24 bits, 01 = 20 bits, 10 = 16 bits, 11 = 24 bits. Bits of the slot beyond the width are ignored, and the unused low bits of the word read zero.
- R3: After the last bit of slot 7 is sampled, all eight words update together and `frame_valid` pulses high for exactly one clock. The words hold until the next complete frame.
- R4: With `cfg_bclk_inv`=0, data is sampled on rising `tdm_bclk` edges; with 1, on falling edges. With `cfg_fclk_inv`=1, the frame clock is inverted, so a falling edge marks the frame start.
- R5: A frame start that arrives before 256 bits have been counted since the previous one realigns the slot counter to it and sets `frame_err`. The flag stays set until reset, and the next complete frame is decoded correctly.
- R6: With `cfg_aux_en`=1, the words for slots 4 to 7 read zero on `ch_words`. Those slots go out during the following frame: `aux_dout[0]` carries slot 4 (left) and slot 5 (right), and `aux_dout[1]` carries slot 6 (left) and slot 7 (right).
- R7: The auxiliary format has 64 `aux_bclk` periods per frame, one per 4 input bits. `aux_lrclk` is low for the left half and high for the right half, 32 aux bits each. Each word starts MSB first one aux bit after the `aux_lrclk` transition, holds the width-masked 24-bit word and then zeros. Data and `aux_lrclk` change only while `aux_bclk` is low and are sampled on its rising edge.
- R8: With `cfg_aux_en`=0, `aux_bclk`, `aux_lrclk` and `aux_dout` stay low.
- R9: After reset, `ch_words`, `frame_valid`, `frame_err` and all auxiliary outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wlen | input | 2 | Slot word width select |
| cfg_bclk_inv | input | 1 | Sample on falling bit clock edges when set |
| cfg_fclk_inv | input | 1 | Invert the frame clock when set |
| cfg_aux_en | input | 1 | Forward slots 4 to 7 to the auxiliary port |
| tdm_bclk | input | 1 | TDM bit clock |
| tdm_fclk | input | 1 | TDM frame clock |
| tdm_din | input | 1 | TDM serial data |
| ch_words | output | 192 | Eight 24-bit channel words, slot 0 in the low bits |
| frame_valid | output | 1 | One-clock strobe when a new frame of words is ready |
| frame_err | output | 1 | Sticky framing error |
| aux_bclk | output | 1 | Auxiliary bit clock |
| aux_lrclk | output | 1 | Auxiliary word clock, low for the left channel |
| aux_dout | output | 2 | Two auxiliary I2S data streams |

## Verification
The bench builds the block with its default parameters: eight slots of 32 bits, 24-bit words and four forwarded slots. It drives the bit clock at one quarter of the system clock. With these defaults the real 256-bit frame and the 64-bit auxiliary frame are both tested: the bench counts every auxiliary bit clock in a frame and decodes both I2S streams with a receiver model. It drives ones in the padding bits, so the effect of each of the three word widths shows up in the output words. It also sends a truncated 100-bit frame, long enough to realign the counter in mid-slot but too short to reach slot 7.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic [1:0] {
        WL_24   = 2'd0,
        WL_20   = 2'd1,
        WL_16   = 2'd2,
        WL_RSVD = 2'd3
    } wlen_e;

    typedef struct packed {
        logic bit_stb;   // one clock at each sampling edge of the bit clock
        logic fclk_act;  // frame clock after polarity correction
        logic data;      // data bit held with the strobe
    } rx_sample_t;

    function automatic int wlen_bits(input wlen_e w);
        case (w)
            WL_20:   return 20;
            WL_16:   return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/tdm_bit_sampler.sv
module tdm_bit_sampler
    import tdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bclk_inv,
    input  logic       fclk_inv,
    input  logic       tdm_bclk,
    input  logic       tdm_fclk,
    input  logic       tdm_din,
    output rx_sample_t smp
);

    logic bclk_q, bclk_qq, fclk_q, din_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            bclk_qq <= 1'b0;
            fclk_q  <= 1'b0;
            din_q   <= 1'b0;
        end else begin
            bclk_q  <= tdm_bclk;
            bclk_qq <= bclk_q;
            fclk_q  <= tdm_fclk;
            din_q   <= tdm_din;
        end
    end

    always_comb begin
        smp.bit_stb  = (bclk_q ^ bclk_inv) & ~(bclk_qq ^ bclk_inv);
        smp.fclk_act = fclk_q ^ fclk_inv;
        smp.data     = din_q;
    end

endmodule

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker #(
    parameter  int FRAME_BITS = 256,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             fclk_act,
    output logic [CNT_W-1:0] pos,
    output logic             synced,
    output logic             frame_err
);

    logic [CNT_W-1:0] cnt;
    logic             fclk_prev;
    logic             start;

    assign start = bit_stb & fclk_act & ~fclk_prev;
    assign pos   = start ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            fclk_prev <= 1'b0;
            synced    <= 1'b0;
            frame_err <= 1'b0;
        end else if (bit_stb) begin
            fclk_prev <= fclk_act;
            cnt       <= pos + 1'b1;
            if (start) begin
                synced <= 1'b1;
                if (synced && cnt != '0)
                    frame_err <= 1'b1;
            end
        end
    end

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

    // R1
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        synced |=> synced);

endmodule

// File: rtl/tdm_slot_capture.sv
module tdm_slot_capture
    import tdm_pkg::*;
#(
    parameter  int SLOTS     = 8,
    parameter  int SLOT_BITS = 32,
    parameter  int WORD_W    = 24,
    parameter  int AUX_SLOTS = 4,
    localparam int BIT_W     = $clog2(SLOT_BITS),
    localparam int CNT_W     = $clog2(SLOTS * SLOT_BITS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_stb,
    input  logic                        data,
    input  logic [CNT_W-1:0]            pos,
    input  logic                        synced,
    input  wlen_e                       wlen,
    input  logic                        aux_en,
    output logic [SLOTS*WORD_W-1:0]     words,
    output logic                        frame_valid,
    output logic [AUX_SLOTS*WORD_W-1:0] aux_words
);

    localparam int FIRST_AUX = SLOTS - AUX_SLOTS;

    logic [CNT_W-BIT_W-1:0] slot_idx;
    logic [BIT_W-1:0]       bit_idx;
    logic [WORD_W-1:0]      asm_w, asm_nx;
    logic [WORD_W-1:0]      slot_q [SLOTS-1];
    int                     nbits;

    assign slot_idx = pos[CNT_W-1:BIT_W];
    assign bit_idx  = pos[BIT_W-1:0];
    assign nbits    = wlen_bits(wlen);

    always_comb begin
        asm_nx = (bit_idx == '0) ? '0 : asm_w;
        for (int b = 0; b < WORD_W; b++) begin
            if (int'(bit_idx) == WORD_W - 1 - b && int'(bit_idx) < nbits)
                asm_nx[b] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_w       <= '0;
            words       <= '0;
            aux_words   <= '0;
            frame_valid <= 1'b0;
            for (int s = 0; s < SLOTS - 1; s++) slot_q[s] <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (bit_stb) begin
                asm_w <= asm_nx;
                if (int'(bit_idx) == SLOT_BITS - 1) begin
                    if (int'(slot_idx) < SLOTS - 1)
                        slot_q[slot_idx] <= asm_w;
                    if (int'(slot_idx) == SLOTS - 1 && synced) begin
                        frame_valid <= 1'b1;
                        for (int s = 0; s < SLOTS; s++) begin
                            logic [WORD_W-1:0] w;
                            w = (s == SLOTS - 1) ? asm_w : slot_q[s];
                            if (s >= FIRST_AUX) begin
                                aux_words[(s-FIRST_AUX)*WORD_W +: WORD_W] <= w;
                                words[s*WORD_W +: WORD_W] <= aux_en ? '0 : w;
                            end else begin
                                words[s*WORD_W +: WORD_W] <= w;
                            end
                        end
                    end
                end
            end
        end
    end

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    // R6
    aux_zero_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid && $past(aux_en) |-> words[SLOTS*WORD_W-1:FIRST_AUX*WORD_W] == '0);

    // R2
    width_pad_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid && $past(wlen) == WL_16 |-> words[(SLOTS-1)*WORD_W +: 8] == 8'h00);

endmodule

// File: rtl/tdm_aux_serializer.sv
module tdm_aux_serializer #(
    parameter  int SLOTS     = 8,
    parameter  int SLOT_BITS = 32,
    parameter  int WORD_W    = 24,
    parameter  int AUX_SLOTS = 4,
    localparam int CNT_W     = $clog2(SLOTS * SLOT_BITS),
    localparam int GRP_W     = $clog2(SLOTS / 2),
    localparam int IDX_W     = CNT_W - GRP_W,
    localparam int STREAMS   = AUX_SLOTS / 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_stb,
    input  logic [CNT_W-1:GRP_W-1]      pos_hi,
    input  logic                        synced,
    input  logic                        aux_en,
    input  logic [AUX_SLOTS*WORD_W-1:0] aux_words,
    output logic                        aux_bclk,
    output logic                        aux_lrclk,
    output logic [STREAMS-1:0]          aux_dout
);

    logic [IDX_W-1:0] aux_idx, sel;
    logic             half;
    logic [IDX_W-2:0] bsel;
    logic [STREAMS-1:0] nxt_bit;

    assign aux_idx = pos_hi[CNT_W-1:GRP_W];
    assign sel     = aux_idx - 1'b1;
    assign half    = sel[IDX_W-1];
    assign bsel    = sel[IDX_W-2:0];

    for (genvar j = 0; j < STREAMS; j++) begin : g_stream
        logic [WORD_W-1:0] cur_w;
        assign cur_w = half ? aux_words[(2*j+1)*WORD_W +: WORD_W]
                            : aux_words[(2*j)*WORD_W +: WORD_W];
        always_comb begin
            nxt_bit[j] = 1'b0;
            for (int b = 0; b < WORD_W; b++) begin
                if (int'(bsel) == WORD_W - 1 - b)
                    nxt_bit[j] = cur_w[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !(aux_en && synced)) begin
            aux_bclk  <= 1'b0;
            aux_lrclk <= 1'b0;
            aux_dout  <= '0;
        end else if (bit_stb) begin
            aux_bclk  <= pos_hi[GRP_W-1];
            aux_lrclk <= aux_idx[IDX_W-1];
            aux_dout  <= nxt_bit;
        end
    end

    // R7
    aux_lr_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(aux_lrclk) |-> !aux_bclk);

    // R8
    aux_off_chk: assert property (@(posedge clk) disable iff (rst)
        !aux_en |=> (!aux_bclk && !aux_lrclk && aux_dout == '0));

endmodule

// File: rtl/tdm_slot_splitter.sv
module tdm_slot_splitter
    import tdm_pkg::*;
#(
    parameter  int SLOTS     = 8,
    parameter  int SLOT_BITS = 32,
    parameter  int WORD_W    = 24,
    parameter  int AUX_SLOTS = 4,
    localparam int CNT_W     = $clog2(SLOTS * SLOT_BITS),
    localparam int GRP_W     = $clog2(SLOTS / 2),
    localparam int STREAMS   = AUX_SLOTS / 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              cfg_wlen,
    input  logic                    cfg_bclk_inv,
    input  logic                    cfg_fclk_inv,
    input  logic                    cfg_aux_en,
    input  logic                    tdm_bclk,
    input  logic                    tdm_fclk,
    input  logic                    tdm_din,
    output logic [SLOTS*WORD_W-1:0] ch_words,
    output logic                    frame_valid,
    output logic                    frame_err,
    output logic                    aux_bclk,
    output logic                    aux_lrclk,
    output logic [STREAMS-1:0]      aux_dout
);

    rx_sample_t                  smp;
    logic [CNT_W-1:0]            pos;
    logic                        synced;
    logic [AUX_SLOTS*WORD_W-1:0] aux_words;

    tdm_bit_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .bclk_inv (cfg_bclk_inv),
        .fclk_inv (cfg_fclk_inv),
        .tdm_bclk (tdm_bclk),
        .tdm_fclk (tdm_fclk),
        .tdm_din  (tdm_din),
        .smp      (smp)
    );

    tdm_frame_tracker #(.FRAME_BITS(SLOTS * SLOT_BITS)) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (smp.bit_stb),
        .fclk_act  (smp.fclk_act),
        .pos       (pos),
        .synced    (synced),
        .frame_err (frame_err)
    );

    tdm_slot_capture #(
        .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .WORD_W(WORD_W), .AUX_SLOTS(AUX_SLOTS)
    ) u_capture (
        .clk         (clk),
        .rst         (rst),
        .bit_stb     (smp.bit_stb),
        .data        (smp.data),
        .pos         (pos),
        .synced      (synced),
        .wlen        (wlen_e'(cfg_wlen)),
        .aux_en      (cfg_aux_en),
        .words       (ch_words),
        .frame_valid (frame_valid),
        .aux_words   (aux_words)
    );

    tdm_aux_serializer #(
        .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .WORD_W(WORD_W), .AUX_SLOTS(AUX_SLOTS)
    ) u_aux (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (smp.bit_stb),
        .pos_hi    (pos[CNT_W-1:GRP_W-1]),
        .synced    (synced),
        .aux_en    (cfg_aux_en),
        .aux_words (aux_words),
        .aux_bclk  (aux_bclk),
        .aux_lrclk (aux_lrclk),
        .aux_dout  (aux_dout)
    );

endmodule

// File: tb/test_tdm_slot_splitter.sv
`timescale 1ns/1ps
module test_tdm_slot_splitter;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cfg_wlen = 2'd0;
    logic         cfg_bclk_inv = 1'b0;
    logic         cfg_fclk_inv = 1'b0;
    logic         cfg_aux_en = 1'b0;
    logic         tdm_bclk = 1'b0;
    logic         tdm_fclk = 1'b0;
    logic         tdm_din = 1'b0;
    logic [191:0] ch_words;
    logic         frame_valid, frame_err, aux_bclk, aux_lrclk;
    logic [1:0]   aux_dout;

    always #2 clk = ~clk;

    tdm_slot_splitter i_tdm_slot_splitter (
        .clk(clk), .rst(rst), .cfg_wlen(cfg_wlen), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_fclk_inv(cfg_fclk_inv), .cfg_aux_en(cfg_aux_en), .tdm_bclk(tdm_bclk),
        .tdm_fclk(tdm_fclk), .tdm_din(tdm_din), .ch_words(ch_words),
        .frame_valid(frame_valid), .frame_err(frame_err), .aux_bclk(aux_bclk),
        .aux_lrclk(aux_lrclk), .aux_dout(aux_dout)
    );

    int nvec = 0, nerr = 0;
    bit done = 0;
    logic [23:0] fw [8];

    // monitor: frame strobes and an I2S receiver for the auxiliary port
    int vcnt, vmulti, aux_rises, rx_idx;
    logic vprev, abclk_prev, rx_last_lr;
    logic [23:0] rx_sh [2];
    logic [23:0] rx_word [4];

    always @(negedge clk) begin
        if (rst) begin
            vcnt = 0; vmulti = 0; aux_rises = 0; rx_idx = 0;
            vprev = 0; abclk_prev = 0; rx_last_lr = 1;
            for (int j = 0; j < 2; j++) rx_sh[j] = '0;
            for (int j = 0; j < 4; j++) rx_word[j] = '0;
        end else begin
            if (frame_valid) vcnt++;
            if (frame_valid && vprev) vmulti++;
            vprev = frame_valid;
            if (aux_bclk && !abclk_prev) begin
                aux_rises++;
                if (aux_lrclk != rx_last_lr) rx_idx = 0; else rx_idx++;
                rx_last_lr = aux_lrclk;
                if (rx_idx >= 1 && rx_idx <= 24)
                    for (int j = 0; j < 2; j++) rx_sh[j] = {rx_sh[j][22:0], aux_dout[j]};
                if (rx_idx == 24)
                    for (int j = 0; j < 2; j++) rx_word[2*j + int'(aux_lrclk)] = rx_sh[j];
            end
            abclk_prev = aux_bclk;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] mask(input logic [23:0] w, input logic [1:0] wl);
        case (wl)
            2'd1:    return w & 24'hFFFFF0;
            2'd2:    return w & 24'hFFFF00;
            default: return w;
        endcase
    endfunction

    task automatic fill(input int seed);
        for (int s = 0; s < 8; s++)
            fw[s] = 24'h9A3C5F ^ 24'(seed * 24'h0137B1) ^ 24'(s * 24'h2D4E69);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tdm_bclk = cfg_bclk_inv;
        tdm_fclk = cfg_fclk_inv;
        tdm_din = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic d, input logic fs);
        tdm_bclk = cfg_bclk_inv;
        tdm_din = d;
        tdm_fclk = fs ^ cfg_fclk_inv;
        repeat (2) @(negedge clk);
        tdm_bclk = ~cfg_bclk_inv;
        repeat (2) @(negedge clk);
    endtask

    // padding bits beyond bit 23 are driven high: the receiver must drop them
    task automatic send_frame(input int nbits);
        for (int p = 0; p < nbits; p++) begin
            int s = p / 32;
            int b = p % 32;
            send_bit((b < 24) ? fw[s][23-b] : 1'b1, p == 0);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_words(input string req, input logic [1:0] wl, input bit aux);
        for (int s = 0; s < 8; s++) begin
            logic [23:0] e = (aux && s >= 4) ? 24'h0 : mask(fw[s], wl);
            chk(req, $sformatf("slot %0d word", s), 32'(ch_words[s*24 +: 24]), 32'(e));
        end
    endtask

    task automatic test_reset();
        cfg_wlen = 2'd0; cfg_bclk_inv = 0; cfg_fclk_inv = 0; cfg_aux_en = 0;
        do_reset();
        chk("R9", "ch_words low", ch_words[31:0], 32'h0);
        chk("R9", "ch_words any", 32'(|ch_words), 32'h0);
        chk("R9", "frame_valid", 32'(frame_valid), 32'h0);
        chk("R9", "frame_err", 32'(frame_err), 32'h0);
        chk("R9", "aux outputs", {29'h0, aux_bclk, aux_lrclk, |aux_dout}, 32'h0);
    endtask

    task automatic test_basic();
        int v0;
        do_reset();
        fill(1);
        v0 = vcnt;
        send_frame(256);
        chk("R3", "strobes per frame", 32'(vcnt - v0), 32'd1);
        check_words("R1", 2'd0, 0);
        fill(2);
        send_frame(256);
        check_words("R1", 2'd0, 0);
        chk("R3", "strobe width", 32'(vmulti), 32'd0);
        chk("R5", "no error on aligned frames", 32'(frame_err), 32'h0);
        chk("R8", "aux bclk idle", 32'(aux_rises), 32'd0);
        chk("R8", "aux lines low", {30'h0, aux_lrclk, |aux_dout}, 32'h0);
    endtask

    task automatic test_width();
        cfg_wlen = 2'd1;
        fill(3);
        send_frame(256);
        check_words("R2", 2'd1, 0);
        cfg_wlen = 2'd2;
        fill(4);
        send_frame(256);
        check_words("R2", 2'd2, 0);
        cfg_wlen = 2'd3;
        fill(5);
        send_frame(256);
        check_words("R2", 2'd3, 0);
        cfg_wlen = 2'd0;
    endtask

    task automatic test_polarity();
        cfg_bclk_inv = 1; cfg_fclk_inv = 1;
        do_reset();
        fill(6);
        send_frame(256);
        check_words("R4", 2'd0, 0);
        fill(7);
        send_frame(256);
        check_words("R4", 2'd0, 0);
        chk("R4", "strobe count", 32'(vcnt), 32'd2);
        cfg_bclk_inv = 0; cfg_fclk_inv = 0;
    endtask

    task automatic test_framing();
        int v0;
        do_reset();
        fill(8);
        send_frame(256);
        chk("R5", "clean before truncation", 32'(frame_err), 32'h0);
        v0 = vcnt;
        fill(9);
        send_frame(100);
        chk("R5", "no strobe on short frame", 32'(vcnt - v0), 32'd0);
        chk("R5", "flag before realign", 32'(frame_err), 32'h0);
        fill(10);
        send_frame(256);
        chk("R5", "flag after early frame edge", 32'(frame_err), 32'h1);
        check_words("R5", 2'd0, 0);
        fill(11);
        send_frame(256);
        chk("R5", "flag sticky", 32'(frame_err), 32'h1);
    endtask

    task automatic test_aux(input logic [1:0] wl);
        logic [23:0] prev [8];
        int r0;
        cfg_aux_en = 1; cfg_wlen = wl;
        do_reset();
        fill(12 + int'(wl));
        send_frame(256);
        for (int s = 0; s < 8; s++) prev[s] = fw[s];
        fill(20 + int'(wl));
        r0 = aux_rises;
        send_frame(256);
        chk("R7", "aux bclk periods per frame", 32'(aux_rises - r0), 32'd64);
        check_words("R6", wl, 1);
        for (int j = 0; j < 4; j++)
            chk("R6", $sformatf("aux word %0d", j), 32'(rx_word[j]), 32'(mask(prev[4+j], wl)));
        cfg_aux_en = 0; cfg_wlen = 2'd0;
    endtask

    initial begin
        #600000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_basic();
        test_width();
        test_polarity();
        test_framing();
        test_aux(2'd0);
        test_aux(2'd2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule